// File: doc/BRIEF.md
# Serialized Systolic Matrix Multiplier

This block multiplies two N×N matrices of unsigned integers, C = A×B, on a small two-dimensional grid of processing elements. The output-stationary array gives each virtual processing element one entry C[i][j] and a running sum over k. The virtual grid is P·σ wide on each side. It is folded onto a P×P physical grid: each physical element serves a σ×σ cluster of virtual elements, one after another, through a modulo-σ phase counter on each axis. One shared multiplier per physical element does the work, and σ² duplicated accumulators hold the state.

Operands travel rightwards (rows of A) and downwards (columns of B). They move one neighbour per macro step, and a macro step lasts σ² cycles. Every hop between elements goes through registers, and `SKEW` adds extra registers on each hop. The edge feeders delay their injection to match, so the operands of every term still meet at the same element in the same macro step. A start pulse opens the load phase. The block then accepts 2·N² operands on a valid/ready handshake, runs the array, streams the N² results and ends with a done pulse.

Top module: `sysmm_array`

## Requirements
- R1: While reset is asserted and right after it, `in_ready`, `out_valid` and `done` are all low.
- R2: `in_ready` rises only in the cycle after a `start` pulse taken while idle. It stays high until exactly 2·N² operands have been accepted: first A, then B, each in row-major order (word index i·N+k for A and k·N+j for B). It is never high together with `out_valid`.
- R3: The results are the exact products C[i][j] = Σk A[i][k]·B[k][j], each at the full width `ACCW`. They appear in row-major order, one per cycle.
- R4: `out_valid` is high for exactly N² consecutive cycles. `done` is high for the single cycle that follows the last result.
- R5: Between the cycle that accepts the last operand and the first result, there are exactly (N + 2·(P−1)·(1+SKEW))·σ² cycles in which the block neither accepts nor presents data.
- R6: A `start` pulse while the array is computing has no effect on the results or on their timing.
- R7: `in_valid` and `in_data` have no effect while `in_ready` is low.
- R8: All operands at 2^W−1 give N·(2^W−1)² in every result entry, with no wrap-around.
- R9: Each `start` clears all accumulators and inter-element registers, so the results of one problem do not depend on the one before it.
- R10: The load phase waits while `in_valid` is low. Gaps in the operand stream do not change the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a new problem when idle |
| in_valid | input | 1 | Operand word present |
| in_ready | output | 1 | Block accepts operands |
| in_data | input | W | Operand word (A then B, row-major) |
| out_valid | output | 1 | Result word present |
| out_data | output | ACCW | Result word C[i][j], row-major |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
The properties take for granted that `rst_n` is released synchronously and that `start` is a single-cycle pulse. They also rely on the host never expecting backpressure on the result stream, because `out_valid` has no ready. The bench drives `start` for one cycle per problem and reads every result on the cycle it appears. It changes its inputs only on falling edges. It also breaks these patterns on purpose where the block has to ignore them: it drives operands and data while the block is not ready, it leaves holes in the operand stream, and it holds `start` high through the computation.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_COMP,
      ST_DRAIN,
      ST_DONE
   } sysmm_state_e;

endpackage

// File: rtl/sysmm_link.sv
// Registered hop between neighbouring elements: one spatial register plus
// DEPTH-1 skew registers, all advanced once per macro step.
module sysmm_link #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= '0;
            else if (clr)   q <= '0;
            else if (shift) q <= d;
         end
      end else begin : g_chain
         logic [WIDTH-1:0] stg [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < DEPTH; s++) stg[s] <= '0;
            end else if (clr) begin
               for (int s = 0; s < DEPTH; s++) stg[s] <= '0;
            end else if (shift) begin
               stg[0] <= d;
               for (int s = 1; s < DEPTH; s++) stg[s] <= stg[s-1];
            end
         end
         assign q = stg[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/sysmm_pe.sv
// One physical element serving a SIGMA x SIGMA cluster of virtual elements
// with a single multiplier and SIGMA*SIGMA accumulators.
module sysmm_pe #(
   parameter int W     = 8,
   parameter int SIGMA = 2,
   parameter int ACCW  = 18
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        run,
   input  logic [SIGMA*W-1:0]          a_vec,
   input  logic [SIGMA*W-1:0]          b_vec,
   output logic [SIGMA*SIGMA*ACCW-1:0] acc_vec
);

   localparam int SPH = SIGMA * SIGMA;
   localparam int PHW = (SIGMA > 1) ? $clog2(SIGMA) : 1;
   localparam int SLW = (SPH > 1) ? $clog2(SPH) : 1;

   logic [PHW-1:0]   ph_row, ph_col;
   logic [SLW-1:0]   slot;
   logic [W-1:0]     a_cur, b_cur;
   logic [2*W-1:0]   prod;
   logic [ACCW-1:0]  acc [SPH];

   assign a_cur = a_vec[ph_row*W +: W];
   assign b_cur = b_vec[ph_col*W +: W];
   assign prod  = a_cur * b_cur;
   assign slot  = SLW'(ph_row) * SLW'(SIGMA) + SLW'(ph_col);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_row <= '0;
         ph_col <= '0;
         for (int s = 0; s < SPH; s++) acc[s] <= '0;
      end else if (clr) begin
         ph_row <= '0;
         ph_col <= '0;
         for (int s = 0; s < SPH; s++) acc[s] <= '0;
      end else if (run) begin
         acc[slot] <= acc[slot] + ACCW'(prod);
         if (ph_col == PHW'(SIGMA - 1)) begin
            ph_col <= '0;
            ph_row <= (ph_row == PHW'(SIGMA - 1)) ? '0 : ph_row + 1'b1;
         end else begin
            ph_col <= ph_col + 1'b1;
         end
      end
   end

   generate
      for (genvar s = 0; s < SPH; s++) begin : g_out
         assign acc_vec[s*ACCW +: ACCW] = acc[s];
      end
   endgenerate

endmodule

// File: rtl/sysmm_array.sv
module sysmm_array #(
   parameter int W     = 8,
   parameter int N     = 3,
   parameter int P     = 2,
   parameter int SIGMA = 2,
   parameter int SKEW  = 0,
   parameter int ACCW  = 2 * W + $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [W-1:0]    in_data,
   output logic            out_valid,
   output logic [ACCW-1:0] out_data,
   output logic            done
);
   import sysmm_pkg::*;

   localparam int VN     = P * SIGMA;
   localparam int HOP    = 1 + SKEW;
   localparam int TSTEPS = N + 2 * (P - 1) * HOP;
   localparam int SPH    = SIGMA * SIGMA;
   localparam int NSQ    = N * N;
   localparam int NLOAD  = 2 * NSQ;
   localparam int IDXW   = $clog2(NLOAD + 1);
   localparam int MW     = (NSQ > 1) ? $clog2(NSQ) : 1;
   localparam int TW     = $clog2(TSTEPS + 1);
   localparam int CW     = (SPH > 1) ? $clog2(SPH) : 1;
   localparam int RW     = $clog2(N + 1);
   localparam int SELW   = (VN * VN > 1) ? $clog2(VN * VN) : 1;
   localparam int LW     = SIGMA * W;

   generate
      if (P * SIGMA < N) begin : g_err_cover
         $error("virtual grid P*SIGMA must cover N");
      end
      if (ACCW < 2 * W + $clog2(N)) begin : g_err_accw
         $error("ACCW too narrow for exact sums");
      end
      if (SKEW < 0 || P < 1 || SIGMA < 1 || N < 1) begin : g_err_range
         $error("bad parameter range");
      end
   endgenerate

   sysmm_state_e     st;
   logic [IDXW-1:0]  idx;
   logic [TW-1:0]    tstep;
   logic [CW-1:0]    cyc;
   logic [RW-1:0]    ri, rj;
   logic [W-1:0]     amat [NSQ];
   logic [W-1:0]     bmat [NSQ];
   logic             clr, run, step_end;

   assign clr       = (st == ST_IDLE) && start;
   assign run       = (st == ST_COMP);
   assign step_end  = run && (cyc == CW'(SPH - 1));
   assign in_ready  = (st == ST_LOAD);
   assign out_valid = (st == ST_DRAIN);
   assign done      = (st == ST_DONE);

   // ---------------- sequencing ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         idx   <= '0;
         tstep <= '0;
         cyc   <= '0;
         ri    <= '0;
         rj    <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               st    <= ST_LOAD;
               idx   <= '0;
               tstep <= '0;
               cyc   <= '0;
            end
            ST_LOAD: if (in_valid) begin
               idx <= idx + 1'b1;
               if (idx == IDXW'(NLOAD - 1)) st <= ST_COMP;
            end
            ST_COMP: begin
               cyc <= step_end ? '0 : cyc + 1'b1;
               if (step_end) begin
                  tstep <= tstep + 1'b1;
                  if (tstep == TW'(TSTEPS - 1)) begin
                     st <= ST_DRAIN;
                     ri <= '0;
                     rj <= '0;
                  end
               end
            end
            ST_DRAIN: begin
               if (rj == RW'(N - 1)) begin
                  rj <= '0;
                  ri <= ri + 1'b1;
                  if (ri == RW'(N - 1)) st <= ST_DONE;
               end else begin
                  rj <= rj + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // ---------------- operand store ----------------
   always_ff @(posedge clk) begin
      if (st == ST_LOAD && in_valid) begin
         if (idx < IDXW'(NSQ)) amat[MW'(idx)] <= in_data;
         else                  bmat[MW'(idx - IDXW'(NSQ))] <= in_data;
      end
   end

   // ---------------- grid ----------------
   logic [LW-1:0]           a_in [P][P];
   logic [LW-1:0]           b_in [P][P];
   logic [SPH*ACCW-1:0]     acc_flat [P][P];
   logic [ACCW-1:0]         cmat [VN*VN];

   generate
      for (genvar pr = 0; pr < P; pr++) begin : g_afeed
         logic [LW-1:0] fa;
         always_comb begin
            for (int a = 0; a < SIGMA; a++) begin
               int row, k;
               row = pr * SIGMA + a;
               k   = int'(tstep) - pr * HOP;
               fa[a*W +: W] = (row < N && k >= 0 && k < N) ?
                              amat[MW'(row * N + k)] : '0;
            end
         end
         assign a_in[pr][0] = fa;
      end

      for (genvar pc = 0; pc < P; pc++) begin : g_bfeed
         logic [LW-1:0] fb;
         always_comb begin
            for (int b = 0; b < SIGMA; b++) begin
               int col, k;
               col = pc * SIGMA + b;
               k   = int'(tstep) - pc * HOP;
               fb[b*W +: W] = (col < N && k >= 0 && k < N) ?
                              bmat[MW'(k * N + col)] : '0;
            end
         end
         assign b_in[0][pc] = fb;
      end

      for (genvar pr = 0; pr < P; pr++) begin : g_row
         for (genvar pc = 0; pc < P; pc++) begin : g_col
            sysmm_pe #(.W(W), .SIGMA(SIGMA), .ACCW(ACCW)) i_pe (
               .clk    (clk),
               .rst_n  (rst_n),
               .clr    (clr),
               .run    (run),
               .a_vec  (a_in[pr][pc]),
               .b_vec  (b_in[pr][pc]),
               .acc_vec(acc_flat[pr][pc])
            );
            if (pc < P - 1) begin : g_hlink
               sysmm_link #(.WIDTH(LW), .DEPTH(HOP)) i_link (
                  .clk(clk), .rst_n(rst_n), .clr(clr), .shift(step_end),
                  .d(a_in[pr][pc]), .q(a_in[pr][pc+1])
               );
            end
            if (pr < P - 1) begin : g_vlink
               sysmm_link #(.WIDTH(LW), .DEPTH(HOP)) i_link (
                  .clk(clk), .rst_n(rst_n), .clr(clr), .shift(step_end),
                  .d(b_in[pr][pc]), .q(b_in[pr+1][pc])
               );
            end
            for (genvar a = 0; a < SIGMA; a++) begin : g_va
               for (genvar b = 0; b < SIGMA; b++) begin : g_vb
                  assign cmat[(pr*SIGMA + a) * VN + pc*SIGMA + b] =
                     acc_flat[pr][pc][(a*SIGMA + b) * ACCW +: ACCW];
               end
            end
         end
      end
   endgenerate

   logic [SELW-1:0] sel;
   assign sel      = SELW'(ri) * SELW'(VN) + SELW'(rj);
   assign out_data = cmat[sel];

endmodule

// File: rtl/sysmm_chk.sv
module sysmm_chk #(
   parameter int N = 3
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic in_valid,
   input logic in_ready,
   input logic out_valid,
   input logic done
);

   logic [15:0] vcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         vcnt <= '0;
      else if (out_valid) vcnt <= vcnt + 1'b1;
      else if (done)      vcnt <= '0;
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!in_ready && !out_valid && !done));

   a_r2_ready_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> $past(start));

   a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   a_r4_done_after_stream: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> done);

   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r4_result_count: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(vcnt) == N * N));

endmodule

bind sysmm_array sysmm_chk #(.N(N)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .done     (done)
);

// File: tb/test_sysmm_array.sv
module test_sysmm_array;

   localparam int W     = 8;
   localparam int N     = 3;
   localparam int P     = 2;
   localparam int SIGMA = 2;
   localparam int SKEW  = 0;
   localparam int ACCW  = 2 * W + $clog2(N);
   localparam int NSQ   = N * N;
   localparam int LAT   = (N + 2 * (P - 1) * (1 + SKEW)) * SIGMA * SIGMA;

   localparam logic [7:0] TBL [3][18] = '{
      '{8'd1, 8'd0, 8'd0, 8'd0, 8'd1, 8'd0, 8'd0, 8'd0, 8'd1,
        8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd9},
      '{8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd9,
        8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1},
      '{8'd0, 8'd255, 8'd3, 8'd17, 8'd0, 8'd128, 8'd200, 8'd5, 8'd1,
        8'd2, 8'd0, 8'd255, 8'd4, 8'd66, 8'd9, 8'd255, 8'd1, 8'd0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [W-1:0]    in_data = '0;
   logic            out_valid;
   logic [ACCW-1:0] out_data;
   logic            done;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   logic [W-1:0] ma [NSQ];
   logic [W-1:0] mb [NSQ];

   always #2 clk = ~clk;

   sysmm_array #(.W(W), .N(N), .P(P), .SIGMA(SIGMA), .SKEW(SKEW), .ACCW(ACCW))
   i_sysmm_array (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
      .out_data(out_data), .done(done)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint model(input int i, input int j);
      longint s = 0;
      for (int k = 0; k < N; k++) s += longint'(ma[i*N+k]) * longint'(mb[k*N+j]);
      return s;
   endfunction

   task automatic run_case(input bit gaps, input bit poke, input string req);
      int fed = 0;
      int cyc = 0;
      int lat = 0;
      bit ok;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(in_ready == 1'b1, "R2 ready after start", in_ready, 1);
      while (fed < 2 * NSQ && cyc < 1000) begin
         if (gaps && (cyc % 2 == 1)) begin
            in_valid = 1'b0;
            in_data  = 8'hEE;
         end else begin
            in_valid = 1'b1;
            in_data  = (fed < NSQ) ? ma[fed] : mb[fed - NSQ];
         end
         ok = in_valid && in_ready;
         @(negedge clk);
         if (ok) fed++;
         cyc++;
      end
      in_valid = 1'b0;
      while (!out_valid && lat < 1000) begin
         if (in_ready) chk(1'b0, "R2 ready beyond load", 1, 0);
         lat++;
         start = poke;
         @(negedge clk);
      end
      start = 1'b0;
      chk(lat == LAT, "R5 latency", lat, LAT);
      for (int e = 0; e < NSQ; e++) begin
         chk(out_valid == 1'b1, "R4 valid run", out_valid, 1);
         chk(longint'(out_data) == model(e / N, e % N), req, out_data, model(e / N, e % N));
         @(negedge clk);
      end
      chk(done == 1'b1 && out_valid == 1'b0, "R4 done after last", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R4 done one cycle", done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet during reset
      chk(!in_ready && !out_valid && !done, "R1 reset", {in_ready, out_valid, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!in_ready && !out_valid && !done, "R1 after reset", {in_ready, out_valid, done}, 0);

      // R7: operands offered while not ready are ignored
      for (int c = 0; c < 5; c++) begin
         in_valid = 1'b1;
         in_data  = 8'hFF;
         @(negedge clk);
         chk(in_ready == 1'b0, "R7 idle not ready", in_ready, 0);
      end
      in_valid = 1'b0;

      // R3: table-driven cases
      for (int t = 0; t < 3; t++) begin
         for (int e = 0; e < NSQ; e++) begin
            ma[e] = TBL[t][e];
            mb[e] = TBL[t][NSQ + e];
         end
         run_case(1'b0, 1'b0, "R3 table");
      end

      // R8: all-maximum operands
      for (int e = 0; e < NSQ; e++) begin ma[e] = 8'hFF; mb[e] = 8'hFF; end
      run_case(1'b0, 1'b0, "R8 all max");

      // R9: small values right after all-max, accumulators must restart
      for (int e = 0; e < NSQ; e++) begin ma[e] = 8'(e); mb[e] = 8'(2); end
      run_case(1'b0, 1'b0, "R9 cleared");

      // R10: holes in the operand stream
      for (int e = 0; e < NSQ; e++) begin ma[e] = 8'($urandom); mb[e] = 8'($urandom); end
      run_case(1'b1, 1'b0, "R10 gaps");

      // R6: start held during compute
      for (int e = 0; e < NSQ; e++) begin ma[e] = 8'($urandom); mb[e] = 8'($urandom); end
      run_case(1'b0, 1'b1, "R6 start ignored");

      // R3 random repeats
      for (int r = 0; r < 3; r++) begin
         for (int e = 0; e < NSQ; e++) begin ma[e] = 8'($urandom); mb[e] = 8'($urandom); end
         run_case(1'b0, 1'b0, "R3 random");
      end

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule